// File: doc/BRIEF.md
# UART Interrupt Enable and Pending Latch

This block sits beside a UART's register file. It stores an 8-bit interrupt enable word and keeps one pending latch per interrupt source. It also folds every enabled pending source into a single active-high interrupt line. The sources are:

- receive-ready
- transmit-empty
- receive line status
- modem status change
- software flow-control Xoff detection
- a rising edge on the RTS input
- a rising edge on the CTS input

Each source is raised by an event from its unit. Each is cleared by a particular register read or a particular event. A status priority encoder elsewhere reads the pending vector to form the interrupt status code.

The receiver, transmitter, modem-status logic and character matcher deliver one-cycle event pulses in the block's clock domain. The bus side delivers one-cycle strobes when the line status, interrupt status or modem status register is read. RTS and CTS are asynchronous pins. Each passes through a two-flop synchronizer before edge detection. A mode input selects between two behaviours: per-character (single transfer) and FIFO block transfer. The mode changes how the receive-ready and transmit-empty sources are raised.

Top module: `uart_irq_ctl`

## Requirements
- R1: After reset the enable readback is 0x00, the pending vector is 0x00 and `irq` is 0.
- R2: A write strobe loads all eight enable bits, and `en_rdata` shows the written value from the next clock cycle onward.
- R3: Pending bit 0 (receive-ready) is set by `rx_load` when `blk_mode`=0, or by `rx_trig` when `blk_mode`=1. The pulse belonging to the other mode has no effect. Pending bit 2 (line status) is set by `rx_err`. A `lsr_rd` strobe clears both bit 0 and bit 2.
- R4: Pending bit 1 (transmit-empty) is cleared by `isr_rd`. When `blk_mode`=0 it is set in every cycle that `thr_empty` is high, so it comes back after a read while the holding register stays empty. When `blk_mode`=1 it is set only in the cycle in which `thr_empty` rises (the level is taken as 0 at reset).
- R5: Pending bit 3 (modem status) is set by `msr_chg` and cleared by `msr_rd`.
- R6: Pending bit 5 (Xoff detected) is set by `xoff_det`. It is cleared by `isr_rd` or by `xon_det`. It is also cleared by `rx_char`, but only while `spec_mode`=1; with `spec_mode`=0, `rx_char` leaves it pending.
- R7: Pending bits 6 and 7 are set by a 0-to-1 transition of `rts_in` and `cts_in` respectively. They appear on the third rising clock edge after the pin changes. A 1-to-0 transition sets nothing. Both bits are cleared by `msr_rd`.
- R8: Enable bit 4 (sleep) is stored and read back, but pending bit 4 is always 0 and the bit never affects `irq`.
- R9: `irq` is high exactly when some pending bit has its enable bit set. A pending source whose enable bit is 0 stays latched and drives `irq` once it is enabled.
- R10: When a set event and a clear event for the same source arrive in the same cycle, the source ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register readback |
| lsr_rd | input | 1 | Line status register read strobe |
| isr_rd | input | 1 | Interrupt status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| blk_mode | input | 1 | 0 = per-character mode, 1 = FIFO block mode |
| rx_load | input | 1 | Character loaded into receive holding register |
| rx_trig | input | 1 | Receive FIFO reached its trigger level |
| rx_err | input | 1 | Receive line error event |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| msr_chg | input | 1 | Modem status change event |
| xoff_det | input | 1 | Xoff character detected |
| xon_det | input | 1 | Xon character detected |
| rx_char | input | 1 | Any character received |
| spec_mode | input | 1 | Special character mode active |
| rts_in | input | 1 | Asynchronous RTS pin |
| cts_in | input | 1 | Asynchronous CTS pin |
| pend | output | 8 | Pending vector, bit positions matching the enable bits |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that every event and read strobe is synchronous to `clk`. Only `rts_in` and `cts_in` may change without regard to the clock. They also assume that a clear strobe with no matching set event in the same cycle is a true clear; the clear properties exclude the same-cycle set case explicitly. The stimulus drives every synchronous input at the falling edge. Strobes are kept sparse, so set, clear and collision cycles all occur. The RTS and CTS pins are toggled at random falling edges, so both rising and falling transitions go through the synchronizer.

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_wr,
  input  logic [7:0] en_wdata,
  output logic [7:0] en_rdata,
  input  logic       lsr_rd,
  input  logic       isr_rd,
  input  logic       msr_rd,
  input  logic       blk_mode,
  input  logic       rx_load,
  input  logic       rx_trig,
  input  logic       rx_err,
  input  logic       thr_empty,
  input  logic       msr_chg,
  input  logic       xoff_det,
  input  logic       xon_det,
  input  logic       rx_char,
  input  logic       spec_mode,
  input  logic       rts_in,
  input  logic       cts_in,
  output logic [7:0] pend,
  output logic       irq
);
  localparam int RXR = 0, TXE = 1, RLS = 2, MSC = 3, SLP = 4, XOF = 5, RTS = 6, CTS = 7;

  logic [7:0] en_q, pend_q, set_v, clr_v;
  logic [2:0] rts_s, cts_s;
  logic       thr_q, rts_rise, cts_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= '0;
    else if (en_wr) en_q <= en_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rts_s <= 3'b111;
      cts_s <= 3'b111;
      thr_q <= 1'b0;
    end else begin
      rts_s <= {rts_s[1:0], rts_in};
      cts_s <= {cts_s[1:0], cts_in};
      thr_q <= thr_empty;
    end

  assign rts_rise = rts_s[1] & ~rts_s[2];
  assign cts_rise = cts_s[1] & ~cts_s[2];

  always_comb begin
    set_v      = '0;
    set_v[RXR] = blk_mode ? rx_trig : rx_load;
    set_v[TXE] = blk_mode ? (thr_empty & ~thr_q) : thr_empty;
    set_v[RLS] = rx_err;
    set_v[MSC] = msr_chg;
    set_v[XOF] = xoff_det;
    set_v[RTS] = rts_rise;
    set_v[CTS] = cts_rise;

    clr_v      = '0;
    clr_v[RXR] = lsr_rd;
    clr_v[TXE] = isr_rd;
    clr_v[RLS] = lsr_rd;
    clr_v[MSC] = msr_rd;
    clr_v[SLP] = 1'b1;
    clr_v[XOF] = isr_rd | xon_det | (spec_mode & rx_char);
    clr_v[RTS] = msr_rd;
    clr_v[CTS] = msr_rd;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= '0;
    else pend_q <= set_v | (pend_q & ~clr_v);

  assign en_rdata = en_q;
  assign pend     = pend_q;
  assign irq      = |(pend_q & en_q);
endmodule

module uart_irq_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_wr,
  input logic [7:0] en_wdata,
  input logic [7:0] en_rdata,
  input logic       lsr_rd,
  input logic       isr_rd,
  input logic       msr_rd,
  input logic       rx_err,
  input logic       thr_empty,
  input logic       msr_chg,
  input logic       xoff_det,
  input logic       xon_det,
  input logic [7:0] pend,
  input logic       irq
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) == 1'b0 |-> (en_rdata == 8'h00 && pend == 8'h00));

  p_write_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> en_rdata == $past(en_wdata));

  p_lsr_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rx_err) |=> !pend[2]);

  p_isr_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !thr_empty) |=> !pend[1]);

  p_msr_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && !msr_chg) |=> !pend[3]);

  p_xon_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xon_det && !xoff_det) |=> !pend[5]);

  p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[4]);

  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((pend & en_rdata) != 8'h00));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && lsr_rd) |=> pend[2]);
endmodule

bind uart_irq_ctl uart_irq_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata), .en_rdata(en_rdata),
  .lsr_rd(lsr_rd), .isr_rd(isr_rd), .msr_rd(msr_rd), .rx_err(rx_err),
  .thr_empty(thr_empty), .msr_chg(msr_chg), .xoff_det(xoff_det), .xon_det(xon_det),
  .pend(pend), .irq(irq)
);

// File: tb/sim_uart_irq_ctl.sv
`timescale 1ns/1ps
module sim_uart_irq_ctl;
  logic clk = 0, rst_n = 0;
  logic en_wr = 0, lsr_rd = 0, isr_rd = 0, msr_rd = 0, blk_mode = 0;
  logic rx_load = 0, rx_trig = 0, rx_err = 0, thr_empty = 0, msr_chg = 0;
  logic xoff_det = 0, xon_det = 0, rx_char = 0, spec_mode = 0, rts_in = 0, cts_in = 0;
  logic [7:0] en_wdata = 0, en_rdata, pend;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0, model_on = 0;

  always #5 clk = ~clk;

  uart_irq_ctl u0 (.*);

  // reference built from the requirements
  logic [7:0] m_en, m_pend;
  logic [2:0] m_rts, m_cts;
  logic m_thr;

  function automatic logic [7:0] next_pend(logic [7:0] cur, logic rr, logic tr);
    logic [7:0] n;
    n = cur;
    if (lsr_rd) begin n[0] = 0; n[2] = 0; end                     // R3
    if ((blk_mode && rx_trig) || (!blk_mode && rx_load)) n[0] = 1; // R3, R10
    if (rx_err) n[2] = 1;
    if (isr_rd) n[1] = 0;                                          // R4
    if (blk_mode ? (thr_empty && !m_thr) : thr_empty) n[1] = 1;
    if (msr_rd) begin n[3] = 0; n[6] = 0; n[7] = 0; end            // R5, R7
    if (msr_chg) n[3] = 1;
    if (rr) n[6] = 1;
    if (tr) n[7] = 1;
    if (isr_rd || xon_det || (spec_mode && rx_char)) n[5] = 0;     // R6
    if (xoff_det) n[5] = 1;
    n[4] = 0;                                                      // R8
    return n;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_en <= 0; m_pend <= 0; m_rts <= 3'b111; m_cts <= 3'b111; m_thr <= 0;
    end else begin
      if (en_wr) m_en <= en_wdata;
      m_pend <= next_pend(m_pend, m_rts[1] && !m_rts[2], m_cts[1] && !m_cts[2]);
      m_rts <= {m_rts[1:0], rts_in};
      m_cts <= {m_cts[1:0], cts_in};
      m_thr <= thr_empty;
    end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(int b);
    case (b)
      0, 2: return "R3";
      1: return "R4";
      3: return "R5";
      4: return "R8";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(negedge clk)
    if (model_on && rst_n) begin
      chk("R2 enable readback", en_rdata, m_en);
      for (int b = 0; b < 8; b++) chk(tag_of(b), pend[b], m_pend[b]);
      chk("R9 irq", irq, |(m_pend & m_en));
    end

  task automatic quiet();
    en_wr = 0; lsr_rd = 0; isr_rd = 0; msr_rd = 0; rx_load = 0; rx_trig = 0;
    rx_err = 0; msr_chg = 0; xoff_det = 0; xon_det = 0; rx_char = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); quiet();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 enable", en_rdata, 8'h00);
    chk("R1 pend", pend, 8'h00);
    chk("R1 irq", irq, 1'b0);
    rst_n = 1;
    step();
    model_on = 1;

    en_wr = 1; en_wdata = 8'h10; step();
    chk("R2 write", en_rdata, 8'h10);
    chk("R8 sleep no irq", irq, 1'b0);

    rx_err = 1; lsr_rd = 1; step();
    chk("R10 set wins", pend[2], 1'b1);
    lsr_rd = 1; step();
    chk("R3 lsr clear", pend[2], 1'b0);

    msr_chg = 1; step();
    chk("R9 disabled latched", {pend[3], irq}, 2'b10);
    en_wr = 1; en_wdata = 8'h08; step();
    chk("R9 enabled asserts", irq, 1'b1);
    msr_rd = 1; step();
    chk("R5 msr clear", pend[3], 1'b0);

    xoff_det = 1; step();
    rx_char = 1; step();
    chk("R6 rx_char without special", pend[5], 1'b1);
    spec_mode = 1; rx_char = 1; step();
    chk("R6 rx_char special", pend[5], 1'b0);
    spec_mode = 0; xoff_det = 1; step();
    xon_det = 1; step();
    chk("R6 xon clear", pend[5], 1'b0);

    blk_mode = 0; thr_empty = 1; step();
    isr_rd = 1; step();
    chk("R4 single mode re-raise", pend[1], 1'b1);
    blk_mode = 1; isr_rd = 1; step();
    step();
    chk("R4 block mode stays clear", pend[1], 1'b0);
    thr_empty = 0; step();

    rx_load = 1; step();
    chk("R3 rx_load ignored in block mode", pend[0], 1'b0);
    rx_trig = 1; step();
    chk("R3 rx_trig", pend[0], 1'b1);
    lsr_rd = 1; blk_mode = 0; step();
    rx_load = 1; step();
    chk("R3 rx_load single", pend[0], 1'b1);
    lsr_rd = 1; step();

    cts_in = 1; step();
    chk("R7 cts edge 1", pend[7], 1'b0);
    step();
    chk("R7 cts edge 2", pend[7], 1'b0);
    step();
    chk("R7 cts edge 3", pend[7], 1'b1);
    msr_rd = 1; step();
    cts_in = 0; repeat (4) step();
    chk("R7 cts fall quiet", pend[7], 1'b0);
    rts_in = 1; repeat (3) step();
    chk("R7 rts rise", pend[6], 1'b1);
    msr_rd = 1; step();

    for (int i = 0; i < 4000; i++) begin
      en_wr = ($urandom % 16) == 0; en_wdata = 8'($urandom);
      lsr_rd = ($urandom % 6) == 0; isr_rd = ($urandom % 6) == 0;
      msr_rd = ($urandom % 6) == 0; rx_load = ($urandom % 5) == 0;
      rx_trig = ($urandom % 5) == 0; rx_err = ($urandom % 7) == 0;
      msr_chg = ($urandom % 7) == 0; xoff_det = ($urandom % 7) == 0;
      xon_det = ($urandom % 9) == 0; rx_char = ($urandom % 4) == 0;
      if (($urandom % 20) == 0) blk_mode = ~blk_mode;
      if (($urandom % 10) == 0) spec_mode = ~spec_mode;
      if (($urandom % 4) == 0) thr_empty = ~thr_empty;
      if (($urandom % 5) == 0) rts_in = ~rts_in;
      if (($urandom % 5) == 0) cts_in = ~cts_in;
      @(posedge clk); @(negedge clk);
    end
    quiet();
    step();
    finish_run();
  end
endmodule